// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block lets a system host take the slave role on an SMBus segment so that a peripheral, temporarily acting as bus master, can push a status report to it. It sits behind a byte-level slave front end. The front end turns line activity into start and stop event pulses and into one-cycle received-byte strobes. For each byte it samples an acknowledge decision from this block.

A notification frame is shaped like a word write. The first byte is the host's own address with the write direction. The next byte carries the 7-bit address of the device raising the notification. Then come two status bytes, least significant first, and a stop. When a frame completes, the block publishes the device address and the 16-bit status word on held output registers and raises a sticky valid flag. The consumer acknowledges with a one-cycle clear. If a second report lands before that clear, an overrun flag is raised and the newer report replaces the older one.

Top module: `hnotify_rx`

## Requirements
- R1: A first byte after a start is acknowledged (ack_out high during its rx_valid cycle) only when bits [7:1] equal host_addr and bit 0, the direction bit, is 0 (write). Any other value, including the read direction (bit 0 = 1), is not acknowledged. ack_out is never high outside an rx_valid cycle.
- R2: Once the first byte has been refused, every further byte of that frame is refused, and a stop ending it publishes nothing.
- R3: The byte after an accepted host address is acknowledged and taken as the device address. Its bits [7:1] become note_dev, and its bit 0 has no effect on any output.
- R4: The next two bytes are acknowledged. The first becomes note_data[7:0] and the second becomes note_data[15:8].
- R5: A frame is published only by a stop that follows exactly two status bytes. note_valid and the new values appear in the cycle after the stop strobe.
- R6: A stop after fewer than two status bytes, or a new start before the stop, discards the partial frame. A fifth byte is refused, and its frame is discarded.
- R7: note_valid stays high until clear is pulsed. A clear without a simultaneous publication drops note_valid and note_overrun in the next cycle.
- R8: A publication while note_valid is high and clear is low sets note_overrun, and the newer values replace the held ones.
- R9: note_dev and note_data change only on a publication.
- R10: After reset, note_valid, note_overrun, note_dev, note_data and ack_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 7 | Programmed host slave address |
| bus_start | input | 1 | Start or repeated-start event pulse |
| bus_stop | input | 1 | Stop event pulse |
| rx_valid | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte, valid with rx_valid |
| ack_out | output | 1 | Acknowledge decision for the current byte |
| clear | input | 1 | Consumer acknowledge of the held report |
| note_valid | output | 1 | A report is held |
| note_overrun | output | 1 | A report was replaced before it was cleared |
| note_dev | output | 7 | Address of the notifying device |
| note_data | output | 16 | Status word of the notifying device |

## Verification
The hardest cases to reach are the ones where a frame is nearly complete and then ends the wrong way. These are a repeated start after the device address and the low status byte, and a fifth byte after a complete frame. In both cases the state built up so far must be thrown away without anything reaching the outputs. The directed tasks build those frames byte by byte on the strobe interface. Each case is followed by a stop, after which the bench confirms that note_valid stays low. Overrun is reached by publishing two full frames back to back with no clear between them. The second frame uses a device byte with its low bit set, so the same run also shows that this bit is dropped.

// File: rtl/hnotify_pkg.sv
package hnotify_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DEV,
      ST_DATA,
      ST_DONE,
      ST_SKIP
   } frame_state_e;
endpackage

// File: rtl/hnotify_frame.sv
module hnotify_frame
   import hnotify_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int NB     = 2,
   parameter int IDX_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-2:0] host_addr,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              ack,
   output logic              dev_we,
   output logic              data_we,
   output logic [IDX_W-1:0]  data_idx,
   output logic              publish
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

   frame_state_e        state_q, state_d;
   logic [IDX_W-1:0]    idx_q, idx_d;

   always_comb begin
      state_d = state_q;
      idx_d   = idx_q;
      ack     = 1'b0;
      dev_we  = 1'b0;
      data_we = 1'b0;
      publish = 1'b0;
      if (bus_start) begin
         state_d = ST_ADDR;
         idx_d   = '0;
      end else if (bus_stop) begin
         publish = (state_q == ST_DONE);
         state_d = ST_IDLE;
      end else if (rx_valid) begin
         unique case (state_q)
            ST_ADDR: begin
               if (rx_byte[BYTE_W-1:1] == host_addr && !rx_byte[0]) begin
                  ack     = 1'b1;
                  state_d = ST_DEV;
               end else begin
                  state_d = ST_SKIP;
               end
            end
            ST_DEV: begin
               ack     = 1'b1;
               dev_we  = 1'b1;
               idx_d   = '0;
               state_d = ST_DATA;
            end
            ST_DATA: begin
               ack     = 1'b1;
               data_we = 1'b1;
               if (idx_q == LAST_IDX) state_d = ST_DONE;
               else                   idx_d   = idx_q + 1'b1;
            end
            ST_DONE: state_d = ST_SKIP;
            default: ;
         endcase
      end
   end

   assign data_idx = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
      end
   end

   AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP && !bus_start) |=> (state_q == ST_SKIP || state_q == ST_IDLE)); // R2
   AST_PUB_ON_STOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      publish |-> (bus_stop && !bus_start)); // R5
endmodule

// File: rtl/hnotify_assemble.sv
module hnotify_assemble #(
   parameter int BYTE_W = 8,
   parameter int NB     = 2,
   parameter int IDX_W  = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dev_we,
   input  logic                 data_we,
   input  logic [IDX_W-1:0]     data_idx,
   input  logic [BYTE_W-1:0]    rx_byte,
   output logic [BYTE_W-2:0]    stage_dev,
   output logic [NB*BYTE_W-1:0] stage_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_dev <= '0;
      else if (dev_we) stage_dev <= rx_byte[BYTE_W-1:1];
   end

   for (genvar g = 0; g < NB; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_data[g*BYTE_W +: BYTE_W] <= '0;
         else if (data_we && data_idx == IDX_W'(g))
            stage_data[g*BYTE_W +: BYTE_W] <= rx_byte;
      end
   end
endmodule

// File: rtl/hnotify_outreg.sv
module hnotify_outreg #(
   parameter int DEV_W  = 7,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              publish,
   input  logic              clear,
   input  logic [DEV_W-1:0]  stage_dev,
   input  logic [DATA_W-1:0] stage_data,
   output logic              note_valid,
   output logic              note_overrun,
   output logic [DEV_W-1:0]  note_dev,
   output logic [DATA_W-1:0] note_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         note_valid   <= 1'b0;
         note_overrun <= 1'b0;
         note_dev     <= '0;
         note_data    <= '0;
      end else if (publish) begin
         note_valid   <= 1'b1;
         note_overrun <= note_valid && !clear;
         note_dev     <= stage_dev;
         note_data    <= stage_data;
      end else if (clear) begin
         note_valid   <= 1'b0;
         note_overrun <= 1'b0;
      end
   end

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (note_valid && !clear) |=> note_valid); // R7
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !publish) |=> (!note_valid && !note_overrun)); // R7
   AST_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(note_overrun) |-> $past(note_valid)); // R8
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !publish |=> ($stable(note_data) && $stable(note_dev))); // R9
endmodule

// File: rtl/hnotify_rx.sv
module hnotify_rx #(
   parameter int BYTE_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-2:0] host_addr,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              ack_out,
   input  logic              clear,
   output logic              note_valid,
   output logic              note_overrun,
   output logic [BYTE_W-2:0] note_dev,
   output logic [DATA_W-1:0] note_data
);
   localparam int NB    = DATA_W / BYTE_W;
   localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
   localparam int DEV_W = BYTE_W - 1;

   if (BYTE_W < 2)                       begin : g_bad_byte  $error("BYTE_W too small");            end
   if (DATA_W % BYTE_W != 0 || NB < 1)   begin : g_bad_data  $error("DATA_W must be whole bytes");  end

   logic              dev_we, data_we, publish;
   logic [IDX_W-1:0]  data_idx;
   logic [DEV_W-1:0]  stage_dev;
   logic [DATA_W-1:0] stage_data;

   hnotify_frame #(.BYTE_W(BYTE_W), .NB(NB), .IDX_W(IDX_W)) i_frame (
      .clk, .rst_n, .host_addr, .bus_start, .bus_stop, .rx_valid, .rx_byte,
      .ack(ack_out), .dev_we, .data_we, .data_idx, .publish
   );

   hnotify_assemble #(.BYTE_W(BYTE_W), .NB(NB), .IDX_W(IDX_W)) i_assemble (
      .clk, .rst_n, .dev_we, .data_we, .data_idx, .rx_byte, .stage_dev, .stage_data
   );

   hnotify_outreg #(.DEV_W(DEV_W), .DATA_W(DATA_W)) i_outreg (
      .clk, .rst_n, .publish, .clear, .stage_dev, .stage_data,
      .note_valid, .note_overrun, .note_dev, .note_data
   );

   AST_ACK_ONLY_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_out |-> rx_valid); // R1
   AST_RISE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(note_valid) |-> $past(bus_stop)); // R5
endmodule

// File: tb/test_hnotify_rx.sv
module test_hnotify_rx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  host_addr = 7'h08;
   logic        bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0, clear = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        ack_out, note_valid, note_overrun;
   logic [6:0]  note_dev;
   logic [15:0] note_data;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hnotify_rx i_hnotify_rx (
      .clk, .rst_n, .host_addr, .bus_start, .bus_stop, .rx_valid, .rx_byte,
      .ack_out, .clear, .note_valid, .note_overrun, .note_dev, .note_data
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_start();
      @(negedge clk); bus_start = 1'b1;
      @(negedge clk); bus_start = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk); bus_stop = 1'b1;
      @(negedge clk); bus_stop = 1'b0;
   endtask

   task automatic do_byte(input logic [7:0] b, input logic exp_ack, input string req);
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      #1 chk(req, ack_out, exp_ack);
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk); clear = 1'b1;
      @(negedge clk); clear = 1'b0;
   endtask

   task automatic full_frame(input logic [7:0] dev, input logic [15:0] w);
      do_start();
      do_byte(8'h10, 1'b1, "R1");
      do_byte(dev, 1'b1, "R3");
      do_byte(w[7:0], 1'b1, "R4");
      do_byte(w[15:8], 1'b1, "R4");
      do_stop();
   endtask

   task automatic t_reset();
      chk("R10 valid", note_valid, 0);
      chk("R10 overrun", note_overrun, 0);
      chk("R10 dev", note_dev, 0);
      chk("R10 data", note_data, 0);
      chk("R10 ack", ack_out, 0);
   endtask

   task automatic t_good();
      full_frame(8'h5A, 16'h1234);
      chk("R5 valid", note_valid, 1);
      chk("R3 dev", note_dev, 7'h2D);
      chk("R4 data", note_data, 16'h1234);
      chk("R8 no overrun", note_overrun, 0);
      repeat (5) @(negedge clk);
      chk("R7 held", note_valid, 1);
      chk("R9 stable", note_data, 16'h1234);
      do_clear();
      chk("R7 cleared", note_valid, 0);
      chk("R9 data kept", note_data, 16'h1234);
   endtask

   task automatic t_foreign(input logic [7:0] first, input string req);
      do_start();
      do_byte(first, 1'b0, req);
      do_byte(8'h20, 1'b0, "R2");
      do_byte(8'h11, 1'b0, "R2");
      do_byte(8'h22, 1'b0, "R2");
      do_stop();
      chk("R2 no publish", note_valid, 0);
   endtask

   task automatic t_short();
      do_start();
      do_byte(8'h10, 1'b1, "R1");
      do_byte(8'h40, 1'b1, "R3");
      do_byte(8'h77, 1'b1, "R4");
      do_stop();
      chk("R6 short", note_valid, 0);
   endtask

   task automatic t_restart();
      do_start();
      do_byte(8'h10, 1'b1, "R1");
      do_byte(8'h40, 1'b1, "R3");
      do_byte(8'h77, 1'b1, "R4");
      do_start();
      do_stop();
      chk("R6 restart", note_valid, 0);
   endtask

   task automatic t_extra();
      do_start();
      do_byte(8'h10, 1'b1, "R1");
      do_byte(8'h40, 1'b1, "R3");
      do_byte(8'h01, 1'b1, "R4");
      do_byte(8'h02, 1'b1, "R4");
      do_byte(8'h03, 1'b0, "R6 extra nack");
      do_stop();
      chk("R6 extra", note_valid, 0);
   endtask

   task automatic t_overrun();
      full_frame(8'h30, 16'hAAAA);
      chk("R8 first", note_overrun, 0);
      full_frame(8'h5B, 16'hBEEF);
      chk("R8 overrun", note_overrun, 1);
      chk("R8 dev newer", note_dev, 7'h2D);
      chk("R8 data newer", note_data, 16'hBEEF);
      do_clear();
      chk("R7 clear valid", note_valid, 0);
      chk("R7 clear overrun", note_overrun, 0);
   endtask

   initial begin
      #1 t_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_good();
      t_foreign(8'h22, "R1 other addr");
      t_foreign(8'h11, "R1 read dir");
      t_short();
      t_restart();
      t_extra();
      t_overrun();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule